// File: doc/BRIEF.md
# Deferred-Entry Instruction Issue Queue

This block is the issue queue of an out-of-order core. Every entry is named by its sequence number and carries a count of source operands it needs and a count already available. Each live entry sits in one of four pools. The waiting pool holds entries with missing operands. The scheduled pool holds entries that are ready to issue. The held pool keeps non-speculative entries until commit releases them. The parked pool keeps memory operations that must be replayed. Broadcast wakeups fill in operands. A squash removes younger work by comparing sequence numbers. Each cycle, up to a width limit of ready entries leave on the issue lanes, and the oldest go first.

Insertion is a valid/ready stream. `ins_ready` is low exactly when the queue is full. An insertion offered while full is not stored and raises `ins_drop` in that cycle. Releases are also a valid/ready stream. `rel_ready` is high only while the execute side still has a free slot this cycle (`slots_busy < IW`). A release offered while `rel_ready` is low has no effect and must be offered again. The issue lanes have no back-pressure. The consumer limits them through `slots_busy`, the number of slots already used this cycle by other sources. Issue lanes are combinational from the queue state and from the release inputs. Every other input takes effect at the next rising clock edge.

Top module: `defer_issue_queue`

## Requirements
- R1: While reset is active and after it ends, the queue is empty: `occ` is 0, `full` is 0, `ins_ready` is 1 and no issue lane is valid.
- R2: An accepted insertion that is non-speculative goes to the held pool. An insertion with `ins_have >= ins_need` goes to the scheduled pool and can issue from the next cycle on. Any other insertion waits.
- R3: Each cycle, scheduled entries issue oldest first, meaning smallest sequence number first. Lanes are filled from lane 0 upward, and lane k carries its tag in `iss_seq[k*SW +: SW]`. The issue lanes plus `slots_busy` never exceed `IW`. An entry that issues leaves the queue at that clock edge.
- R4: An accepted release whose `rel_seq` equals a held entry's sequence number issues that entry in the same cycle on lane 0 and takes one slot. A release that matches no held entry has no effect.
- R5: Each wake lane whose sequence number matches a waiting entry adds one ready operand to it. Once the ready count reaches the needed count, the entry is issuable from the next cycle on. Wakes aimed at entries that are not waiting are ignored.
- R6: A squash with value S removes every waiting, held or parked entry whose sequence number is greater than S. Scheduled entries stay.
- R7: When an insertion and a squash arrive in the same cycle, the squash applies first. The new entry is kept only if its sequence number is not greater than S.
- R8: An insertion with `ins_park=1` and `ins_mem=1` enters the parked pool. It counts toward occupancy and does not issue. For a non-memory entry, `ins_park` is ignored and the entry is routed as in R2.
- R9: A `replay` pulse moves every parked entry into the scheduled pool, and those entries are issuable from the next cycle on.
- R10: `full` is high when `occ` equals `N`. While full, `ins_ready` is low, and an offered insertion raises `ins_drop` and is not stored.
- R11: `occ` equals the number of entries held across all pools.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insertion offered |
| ins_ready | output | 1 | Queue can accept an insertion |
| ins_seq | input | SW | Sequence number of the new entry |
| ins_need | input | CW | Source operands required |
| ins_have | input | CW | Source operands already ready |
| ins_nonspec | input | 1 | Entry must wait for a commit release |
| ins_mem | input | 1 | Entry is a memory operation |
| ins_park | input | 1 | Place the memory entry in the replay pool |
| ins_drop | output | 1 | Insertion refused because the queue is full |
| wake_valid | input | WK | Per-lane wakeup strobe |
| wake_seq | input | WK*SW | Per-lane dependent sequence number |
| rel_valid | input | 1 | Commit release offered |
| rel_ready | output | 1 | A slot is free for a release |
| rel_seq | input | SW | Sequence number being released |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SW | Youngest surviving sequence number |
| replay | input | 1 | Return all parked entries to scheduling |
| slots_busy | input | $clog2(IW+1) | Issue slots already used this cycle |
| iss_valid | output | IW | Per-lane issue strobe |
| iss_seq | output | IW*SW | Per-lane issued sequence number |
| occ | output | $clog2(N+1) | Number of live entries |
| full | output | 1 | Occupancy equals N |

## Verification
Issue lanes, `rel_ready` and `ins_drop` depend on the current state and the current inputs, so they are due in the same cycle as their stimulus. Pool moves caused by insertion, wakeup, replay and squash show up on `occ` and on the issue lanes only one cycle later. The bench drives inputs after the falling edge and compares every output against its behavioural model just before the next rising edge. It updates the model at that same point. This keeps each comparison in the cycle where the result is due and never at a clock edge.

// File: rtl/diq_pkg.sv
package diq_pkg;
  typedef enum logic [2:0] {
    P_FREE  = 3'd0,
    P_WAIT  = 3'd1,
    P_SCHED = 3'd2,
    P_HELD  = 3'd3,
    P_PARK  = 3'd4
  } pool_e;
endpackage

// File: rtl/diq_wake_count.sv
// Per-entry operand counter: adds matching wake lanes, saturating at need.
module diq_wake_count #(
  parameter int SW = 8,
  parameter int CW = 2,
  parameter int WK = 2
) (
  input  logic [WK-1:0]    wake_valid,
  input  logic [WK*SW-1:0] wake_seq,
  input  logic             active,
  input  logic [SW-1:0]    my_seq,
  input  logic [CW-1:0]    have,
  input  logic [CW-1:0]    need,
  output logic [CW-1:0]    have_nx,
  output logic             now_rdy
);
  int cnt;
  int sum;

  always_comb begin
    cnt = 0;
    for (int k = 0; k < WK; k++) begin
      if (wake_valid[k] && wake_seq[k*SW +: SW] == my_seq) cnt = cnt + 1;
    end
    sum = int'(have) + (active ? cnt : 0);
    if (sum > int'(need)) sum = int'(need);
    have_nx = CW'(sum);
    now_rdy = active && (sum >= int'(need));
  end
endmodule

// File: rtl/diq_free_slot.sv
// Lowest-index free entry finder.
module diq_free_slot #(
  parameter int N = 8,
  localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   busy,
  output logic           found,
  output logic [IXW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IXW'(i);
      end
    end
  end
endmodule

// File: rtl/diq_oldest_pick.sv
// Picks up to IW candidates in ascending sequence order.
module diq_oldest_pick #(
  parameter int N  = 8,
  parameter int SW = 8,
  parameter int IW = 2,
  localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     cand,
  input  logic [N*SW-1:0]  seqs,
  output logic [IW-1:0]    pick_v,
  output logic [IW*IXW-1:0] pick_i
);
  logic [N-1:0]  taken;
  logic [SW-1:0] best [IW];
  logic [IXW-1:0] bidx [IW];

  always_comb begin
    taken  = '0;
    pick_v = '0;
    pick_i = '0;
    for (int k = 0; k < IW; k++) begin
      best[k] = '0;
      bidx[k] = '0;
      for (int i = 0; i < N; i++) begin
        if (cand[i] && !taken[i] && (!pick_v[k] || seqs[i*SW +: SW] < best[k])) begin
          pick_v[k] = 1'b1;
          best[k]   = seqs[i*SW +: SW];
          bidx[k]   = IXW'(i);
        end
      end
      if (pick_v[k]) taken[bidx[k]] = 1'b1;
      pick_i[k*IXW +: IXW] = bidx[k];
    end
  end

  // R3: picks are compact and come out in ascending age order
  for (genvar k = 1; k < IW; k++) begin : g_ord
    a_r3_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
      pick_v[k] |-> (pick_v[k-1] && best[k-1] <= best[k]));
  end
endmodule

// File: rtl/defer_issue_queue.sv
module defer_issue_queue
  import diq_pkg::*;
#(
  parameter int N  = 8,
  parameter int SW = 8,
  parameter int CW = 2,
  parameter int IW = 2,
  parameter int WK = 2,
  localparam int BW  = $clog2(IW + 1),
  localparam int OW  = $clog2(N + 1),
  localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SW-1:0]    ins_seq,
  input  logic [CW-1:0]    ins_need,
  input  logic [CW-1:0]    ins_have,
  input  logic             ins_nonspec,
  input  logic             ins_mem,
  input  logic             ins_park,
  output logic             ins_drop,
  input  logic [WK-1:0]    wake_valid,
  input  logic [WK*SW-1:0] wake_seq,
  input  logic             rel_valid,
  output logic             rel_ready,
  input  logic [SW-1:0]    rel_seq,
  input  logic             sq_valid,
  input  logic [SW-1:0]    sq_seq,
  input  logic             replay,
  input  logic [BW-1:0]    slots_busy,
  output logic [IW-1:0]    iss_valid,
  output logic [IW*SW-1:0] iss_seq,
  output logic [OW-1:0]    occ,
  output logic             full
);
  pool_e          st_q   [N];
  logic [SW-1:0]  seq_q  [N];
  logic [CW-1:0]  need_q [N];
  logic [CW-1:0]  have_q [N];
  logic [CW-1:0]  have_nx[N];
  logic [N-1:0]   now_rdy, kill, cand, used, take;
  logic [N*SW-1:0] seq_flat;
  logic           fr_found, rel_hit, alloc;
  logic [IXW-1:0] fr_idx, rel_idx;
  logic [IW-1:0]  pk_v;
  logic [IW*IXW-1:0] pk_i;
  logic [OW-1:0]  park_cnt;
  int             avail;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign used[i] = (st_q[i] != P_FREE);
    assign cand[i] = (st_q[i] == P_SCHED);
    assign kill[i] = sq_valid && (seq_q[i] > sq_seq);
    assign seq_flat[i*SW +: SW] = seq_q[i];
    diq_wake_count #(.SW(SW), .CW(CW), .WK(WK)) u_wake (
      .wake_valid(wake_valid), .wake_seq(wake_seq),
      .active(st_q[i] == P_WAIT), .my_seq(seq_q[i]),
      .have(have_q[i]), .need(need_q[i]),
      .have_nx(have_nx[i]), .now_rdy(now_rdy[i])
    );
  end

  diq_free_slot #(.N(N)) u_free (.busy(used), .found(fr_found), .idx(fr_idx));

  diq_oldest_pick #(.N(N), .SW(SW), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(cand), .seqs(seq_flat),
    .pick_v(pk_v), .pick_i(pk_i)
  );

  always_comb begin
    occ = '0;
    park_cnt = '0;
    for (int i = 0; i < N; i++) begin
      occ = occ + OW'(used[i]);
      park_cnt = park_cnt + OW'(st_q[i] == P_PARK);
    end
  end

  assign full      = (occ == OW'(N));
  assign ins_ready = !full;
  assign ins_drop  = ins_valid && full;
  assign rel_ready = (slots_busy < BW'(IW));
  assign alloc     = ins_valid && ins_ready && fr_found &&
                     !(sq_valid && (ins_seq > sq_seq));

  // Commit release lookup: exact sequence match among held entries.
  always_comb begin
    rel_hit = 1'b0;
    rel_idx = '0;
    if (rel_valid && rel_ready) begin
      for (int i = 0; i < N; i++) begin
        if (st_q[i] == P_HELD && seq_q[i] == rel_seq && !kill[i]) begin
          rel_hit = 1'b1;
          rel_idx = IXW'(i);
        end
      end
    end
  end

  // Lane assembly: release on lane 0, pool picks after it, within width.
  always_comb begin
    int lane;
    iss_valid = '0;
    iss_seq   = '0;
    take      = '0;
    avail     = IW - int'(slots_busy) - (rel_hit ? 1 : 0);
    if (rel_hit) begin
      iss_valid[0]    = 1'b1;
      iss_seq[0 +: SW] = seq_q[rel_idx];
      take[rel_idx]   = 1'b1;
    end
    for (int j = 0; j < IW; j++) begin
      lane = j + (rel_hit ? 1 : 0);
      if (pk_v[j] && j < avail && lane < IW) begin
        iss_valid[lane]          = 1'b1;
        iss_seq[lane*SW +: SW]   = seq_q[pk_i[j*IXW +: IXW]];
        take[pk_i[j*IXW +: IXW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        st_q[i]   <= P_FREE;
        seq_q[i]  <= '0;
        need_q[i] <= '0;
        have_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        case (st_q[i])
          P_SCHED: if (take[i]) st_q[i] <= P_FREE;
          P_HELD:  if (take[i] || kill[i]) st_q[i] <= P_FREE;
          P_WAIT: begin
            if (kill[i]) st_q[i] <= P_FREE;
            else begin
              have_q[i] <= have_nx[i];
              if (now_rdy[i]) st_q[i] <= P_SCHED;
            end
          end
          P_PARK: begin
            if (kill[i]) st_q[i] <= P_FREE;
            else if (replay) st_q[i] <= P_SCHED;
          end
          default: ;
        endcase
        if (alloc && fr_idx == IXW'(i)) begin
          seq_q[i]  <= ins_seq;
          need_q[i] <= ins_need;
          have_q[i] <= ins_have;
          if (ins_park && ins_mem)      st_q[i] <= P_PARK;
          else if (ins_nonspec)         st_q[i] <= P_HELD;
          else if (ins_have >= ins_need) st_q[i] <= P_SCHED;
          else                          st_q[i] <= P_WAIT;
        end
      end
    end
  end

  // R3: issue never exceeds the width left by other sources
  a_r3_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (slots_busy <= BW'(IW)) |-> (($countones(iss_valid) + int'(slots_busy)) <= IW));
  // R11: occupancy bounded and grows by at most one entry per cycle
  a_r11_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= N);
  a_r11_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(occ) <= int'($past(occ)) + 1);
  // R10: a full queue never grows
  a_r10_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> occ <= $past(occ));
  // R9: replay empties the parked pool unless a new park arrives with it
  a_r9_replay_drains: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (park_cnt == '0) || $past(alloc && ins_park && ins_mem));
endmodule

// File: tb/defer_issue_queue_bench.sv
module defer_issue_queue_bench;
  localparam int N = 8, SW = 8, CW = 2, IW = 2, WK = 2;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_nonspec = 0, ins_mem = 0, ins_park = 0;
  logic [SW-1:0] ins_seq = 0, rel_seq = 0, sq_seq = 0;
  logic [CW-1:0] ins_need = 0, ins_have = 0;
  logic [WK-1:0] wake_valid = 0;
  logic [WK*SW-1:0] wake_seq = 0;
  logic rel_valid = 0, sq_valid = 0, replay = 0;
  logic [1:0] slots_busy = 0;
  logic ins_ready, ins_drop, rel_ready, full;
  logic [IW-1:0] iss_valid;
  logic [IW*SW-1:0] iss_seq;
  logic [3:0] occ;

  defer_issue_queue #(.N(N), .SW(SW), .CW(CW), .IW(IW), .WK(WK)) u_defer_issue_queue (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_seq(ins_seq), .ins_need(ins_need), .ins_have(ins_have),
    .ins_nonspec(ins_nonspec), .ins_mem(ins_mem), .ins_park(ins_park),
    .ins_drop(ins_drop), .wake_valid(wake_valid), .wake_seq(wake_seq),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_seq(rel_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .replay(replay),
    .slots_busy(slots_busy), .iss_valid(iss_valid), .iss_seq(iss_seq),
    .occ(occ), .full(full)
  );

  always #(PER/2) clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  // model: 1 wait, 2 scheduled, 3 held, 4 parked
  int m_seq[$], m_st[$], m_need[$], m_have[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic idle();
    ins_valid = 0; ins_nonspec = 0; ins_mem = 0; ins_park = 0;
    ins_need = 0; ins_have = 0; wake_valid = 0; rel_valid = 0;
    sq_valid = 0; replay = 0; slots_busy = 0;
  endtask

  // Compare against the model just before the edge, then advance the model.
  task automatic cyc();
    int relk, avail, sz, lanes, best, bi, cnt;
    int exp_v[IW], exp_s[IW];
    bit used[$];
    bit was_full;
    #1;
    sz = m_seq.size();
    was_full = (sz == N);
    relk = -1;
    if (rel_valid && slots_busy < IW)
      foreach (m_seq[i])
        if (m_st[i] == 3 && m_seq[i] == rel_seq && !(sq_valid && m_seq[i] > sq_seq)) relk = i;
    avail = IW - slots_busy - ((relk >= 0) ? 1 : 0);
    for (int k = 0; k < IW; k++) begin exp_v[k] = 0; exp_s[k] = 0; end
    lanes = 0;
    foreach (m_seq[i]) used.push_back(0);
    if (relk >= 0) begin exp_v[0] = 1; exp_s[0] = m_seq[relk]; used[relk] = 1; lanes = 1; end
    for (int p = 0; p < avail; p++) begin
      bi = -1; best = 0;
      foreach (m_seq[i])
        if (m_st[i] == 2 && !used[i] && (bi < 0 || m_seq[i] < best)) begin bi = i; best = m_seq[i]; end
      if (bi >= 0) begin exp_v[lanes] = 1; exp_s[lanes] = best; used[bi] = 1; lanes++; end
    end
    chk("R11", "occ", int'(occ), sz);
    chk("R10", "full", int'(full), int'(was_full));
    chk("R10", "ins_ready", int'(ins_ready), int'(!was_full));
    chk("R10", "ins_drop", int'(ins_drop), int'(ins_valid && was_full));
    chk("R4", "rel_ready", int'(rel_ready), int'(slots_busy < IW));
    for (int k = 0; k < IW; k++) begin
      chk(cur_req, $sformatf("iss_valid[%0d]", k), int'(iss_valid[k]), exp_v[k]);
      if (exp_v[k]) chk(cur_req, $sformatf("iss_seq[%0d]", k), int'(iss_seq[k*SW +: SW]), exp_s[k]);
    end
    // advance model
    foreach (m_seq[i]) begin
      if (used[i]) m_st[i] = 0;
      else if (sq_valid && m_seq[i] > sq_seq && m_st[i] != 2) m_st[i] = 0;
      else if (m_st[i] == 1) begin
        cnt = 0;
        for (int k = 0; k < WK; k++)
          if (wake_valid[k] && wake_seq[k*SW +: SW] == m_seq[i]) cnt++;
        m_have[i] = m_have[i] + cnt;
        if (m_have[i] > m_need[i]) m_have[i] = m_need[i];
        if (m_have[i] >= m_need[i]) m_st[i] = 2;
      end else if (m_st[i] == 4 && replay) m_st[i] = 2;
    end
    for (int i = m_seq.size() - 1; i >= 0; i--)
      if (m_st[i] == 0) begin
        m_seq.delete(i); m_st.delete(i); m_need.delete(i); m_have.delete(i);
      end
    if (ins_valid && !was_full && !(sq_valid && ins_seq > sq_seq)) begin
      m_seq.push_back(ins_seq); m_need.push_back(ins_need); m_have.push_back(ins_have);
      if (ins_park && ins_mem) m_st.push_back(4);
      else if (ins_nonspec) m_st.push_back(3);
      else if (ins_have >= ins_need) m_st.push_back(2);
      else m_st.push_back(1);
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic put(int s, int need, int have, bit ns, bit mem, bit park, int busy);
    ins_valid = 1; ins_seq = SW'(s); ins_need = CW'(need); ins_have = CW'(have);
    ins_nonspec = ns; ins_mem = mem; ins_park = park; slots_busy = 2'(busy);
    cyc();
  endtask

  task automatic wake2(int a, int b, int busy);
    wake_valid = 2'b11; wake_seq = {SW'(b), SW'(a)}; slots_busy = 2'(busy);
    cyc();
  endtask

  initial begin
    #(PER * 150000);
    fails++; checks++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int nx;
    idle();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "occ in reset", int'(occ), 0);
    chk("R1", "iss_valid in reset", int'(iss_valid), 0);
    rst_n = 1;
    cyc();
    // R2: routing by readiness and speculation
    cur_req = "R2";
    put(10, 0, 0, 0, 0, 0, 0);
    put(11, 1, 0, 0, 0, 0, 0);
    put(12, 0, 0, 1, 0, 0, 0);
    cyc();
    // R5: wake the waiter, wake aimed at held entry ignored
    cur_req = "R5";
    wake2(11, 12, 0);
    cyc();
    // R4: mismatched release then exact one
    cur_req = "R4";
    rel_valid = 1; rel_seq = 13; cyc();
    rel_valid = 1; rel_seq = 12; cyc();
    // R3: build a backlog with slots taken, then drain oldest-first
    cur_req = "R3";
    put(30, 0, 0, 0, 0, 0, 2);
    put(25, 0, 0, 0, 0, 0, 2);
    put(27, 0, 0, 0, 0, 0, 2);
    put(21, 0, 0, 0, 0, 0, 2);
    put(29, 1, 1, 0, 0, 0, 2);
    put(33, 0, 0, 1, 0, 0, 2);
    slots_busy = 1; cyc();
    cur_req = "R4";
    rel_valid = 1; rel_seq = 33; cyc();
    cur_req = "R3";
    repeat (3) cyc();
    // R8/R9: parking and replay
    cur_req = "R8";
    put(40, 0, 0, 0, 1, 1, 0);
    put(41, 0, 0, 0, 1, 1, 0);
    put(42, 0, 0, 0, 0, 1, 0);
    cyc();
    cur_req = "R9";
    replay = 1; cyc();
    repeat (2) cyc();
    // R6: squash across pools, scheduled entry survives
    cur_req = "R6";
    put(49, 0, 0, 0, 0, 0, 2);
    put(50, 1, 0, 0, 0, 0, 2);
    put(51, 1, 0, 0, 0, 0, 2);
    put(52, 2, 0, 0, 0, 0, 2);
    put(53, 0, 0, 1, 0, 0, 2);
    put(54, 0, 0, 0, 1, 1, 2);
    sq_valid = 1; sq_seq = 50; slots_busy = 2; cyc();
    wake2(50, 51, 2);
    repeat (3) cyc();
    // R7: squash with same-cycle insert
    cur_req = "R7";
    sq_valid = 1; sq_seq = 60; ins_valid = 1; ins_seq = 61; cyc();
    sq_valid = 1; sq_seq = 60; ins_valid = 1; ins_seq = 59; cyc();
    repeat (2) cyc();
    // R10: fill with waiters, overflow is dropped
    cur_req = "R10";
    for (int i = 0; i < N + 2; i++) put(70 + i, 3, 0, 0, 0, 0, 0);
    cyc();
    sq_valid = 1; sq_seq = 69; cyc();
    cyc();
    // mixed traffic
    cur_req = "R3";
    nx = 90;
    for (int c = 0; c < 500; c++) begin
      if (nx < 250 && ($urandom % 5) < 2) begin
        ins_valid = 1; ins_seq = SW'(nx); nx++;
        ins_need = CW'($urandom % 3); ins_have = CW'($urandom % 2);
        if (ins_have > ins_need) ins_have = ins_need;
        ins_nonspec = (($urandom % 6) == 0);
        ins_mem = (($urandom % 4) == 0); ins_park = (($urandom % 2) == 0);
      end
      for (int k = 0; k < WK; k++) begin
        wake_valid[k] = ($urandom % 2);
        wake_seq[k*SW +: SW] = SW'(nx - 1 - int'($urandom % 8));
      end
      rel_valid = (($urandom % 4) == 0); rel_seq = SW'(nx - 1 - int'($urandom % 10));
      sq_valid = (($urandom % 25) == 0); sq_seq = SW'(nx - 1 - int'($urandom % 4));
      replay = (($urandom % 10) == 0);
      slots_busy = 2'($urandom % 3);
      cyc();
    end
    summary();
    $finish;
  end
endmodule